// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

This block connects a byte-wide microprocessor bus to two general-purpose 8-bit ports, called A and B. Each port has three registers: an output register, a data direction register that sets each pin as input (0) or output (1), and a control register. Each port also has two handshake lines. The first control line (C1) is always an input. The second control line (C2) is an input or an output, set by software.

Edges on the control lines set per-port transition flags. A data read of a port clears them. Each flag can raise a single active-high interrupt. When C2 is an output, it can be held at a fixed level, or it can run a read handshake or a one-clock read pulse.

Software sees four register slots. The slot decode ignores all address bits above bit 1.

The C2 output of each port is driven by a small state machine. Its states are:
- `C2S_INPUT`: the line is released.
- `C2S_LEVEL_LOW` and `C2S_LEVEL_HIGH`: manual levels.
- `C2S_READY`: the line is high, waiting for a data read.
- `C2S_HS_WAIT`: the line is low until the next active C1 edge.
- `C2S_PULSE`: the line is low for a single clock.

Its transitions are:
- **to-input** happens when control bit 5 is 0.
- **to-level** happens for modes 110 and 111.
- **arm** enters `C2S_READY` in modes 100 or 101 when no data read occurs.
- **read-drop** enters `C2S_HS_WAIT` in mode 100, or `C2S_PULSE` in mode 101, on a data read.
- **edge-release** goes from `C2S_HS_WAIT` to `C2S_READY` on the active C1 edge.
- **pulse-end** goes from `C2S_PULSE` to `C2S_READY` one clock later.

Top module: `byte_port_adapter`

## Requirements
- R1: The low two address bits select the register. Slot 0 is port A data, slot 1 is control A, slot 2 is port B data and slot 3 is control B. Control bit 2 decides what a data slot reaches. When bit 2 is 0, the slot reaches the direction register. When bit 2 is 1, writes go to the output register and reads return the port value. The direction and output registers drive `pX_dir` and `pX_out`.
- R2: The port value takes each bit from the pin when its direction bit is 0, and from the output register when its direction bit is 1.
- R3: A control write changes only bits 5:0. Bits 7 and 6 are the C1 and C2 flags and are read-only.
- R4: Control bit 1 selects the active C1 edge: 1 means rising, 0 means falling. An active edge sets bit 7 once, three clock edges after the pin changes, because of the two-flop synchronizer. Edges of the other polarity are ignored.
- R5: When bit 5 is 0, C2 is an input: `cX2_oe` is low, and bit 4 selects the active edge the same way as bit 1 does for C1. An active edge sets bit 6. When bit 5 is 1, C2 edges are ignored, and any control write that leaves bit 5 at 1 clears bit 6.
- R6: `irq` is high exactly while some port has bits 7 and 0 both set, or has bit 6 set with bit 5 clear and bit 3 set.
- R7: A data read with control bit 2 at 1 clears bits 7 and 6 of that port. A read of the direction register leaves them unchanged.
- R8: The debug read strobe returns the same data as a normal read but never clears a flag.
- R9: With bits 5:3 at 110 the C2 line is driven low. With bits 5:3 at 111 it is driven high. The level takes effect one clock after the control register holds the mode.
- R10: With bits 5:3 at 100 the C2 line is high until a data read of that port. It then goes low from the clock edge of the read until the next active C1 edge.
- R11: With bits 5:3 at 101, a data read of that port drives the C2 line low for exactly one clock.
- R12: Reset clears both control registers, both direction registers and both output registers, and deasserts `irq`.
- R13: Address bits above bit 1 have no effect on which register is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address; only bits 1:0 decoded |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe with flag side effects |
| dbg_rd | input | 1 | Side-effect-free read strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, zero when no read strobe is high |
| pa_in | input | DATA_W | Port A pin inputs |
| pa_out | output | DATA_W | Port A output register |
| pa_dir | output | DATA_W | Port A direction (1 = output) |
| pb_in | input | DATA_W | Port B pin inputs |
| pb_out | output | DATA_W | Port B output register |
| pb_dir | output | DATA_W | Port B direction |
| ca1_in | input | 1 | Port A C1 control input |
| ca2_in | input | 1 | Port A C2 pin, input side |
| ca2_out | output | 1 | Port A C2 output level |
| ca2_oe | output | 1 | Port A C2 output enable |
| cb1_in | input | 1 | Port B C1 control input |
| cb2_in | input | 1 | Port B C2 pin, input side |
| cb2_out | output | 1 | Port B C2 output level |
| cb2_oe | output | 1 | Port B C2 output enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check the following on every cycle:
- a port whose C2 is an output never holds a C2 flag;
- `irq` is never high without some flag;
- flags survive control writes and debug reads, and a clean data read empties them;
- a C2 output configured for a level, a pulse or input mode settles to the expected pin state one clock later.

Only the bench scenarios can show the rest:
- the synchronizer latency and the single setting per edge;
- edge polarity selection;
- the exact mixing of pins and output register in a port read;
- release of the handshake by C1;
- the aliasing of the upper address bits;
- the reset values.

// File: rtl/pia_pkg.sv
package pia_pkg;
    localparam int CTL_W       = 8;
    localparam int B_C1_FLAG   = 7;
    localparam int B_C2_FLAG   = 6;
    localparam int B_C2_DIR    = 5;
    localparam int B_C2_CFG_HI = 4;
    localparam int B_C2_CFG_LO = 3;
    localparam int B_SEL       = 2;
    localparam int B_C1_POL    = 1;
    localparam int B_C1_EN     = 0;

    typedef enum logic [2:0] {
        C2S_INPUT      = 3'd0,
        C2S_LEVEL_LOW  = 3'd1,
        C2S_LEVEL_HIGH = 3'd2,
        C2S_READY      = 3'd3,
        C2S_HS_WAIT    = 3'd4,
        C2S_PULSE      = 3'd5
    } c2_state_e;

    typedef enum logic [1:0] {
        C2M_HANDSHAKE = 2'b00,
        C2M_PULSE     = 2'b01,
        C2M_LOW       = 2'b10,
        C2M_HIGH      = 2'b11
    } c2_mode_e;
endpackage

// File: rtl/pia_edge_sync.sv
module pia_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pia_c2_fsm.sv
module pia_c2_fsm
    import pia_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       data_rd,
    input  logic       c1_active,
    output logic       c2_out,
    output logic       c2_oe
);
    c2_state_e state_q, state_d;
    c2_mode_e  sub_mode;

    assign sub_mode = c2_mode_e'(mode[1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C2S_INPUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!mode[2]) begin
            state_d = C2S_INPUT;                       // to-input
        end else begin
            unique case (sub_mode)
                C2M_LOW:  state_d = C2S_LEVEL_LOW;     // to-level
                C2M_HIGH: state_d = C2S_LEVEL_HIGH;    // to-level
                C2M_HANDSHAKE: begin
                    if (data_rd)
                        state_d = C2S_HS_WAIT;         // read-drop
                    else if (state_q == C2S_HS_WAIT)
                        state_d = c1_active ? C2S_READY : C2S_HS_WAIT;  // edge-release
                    else
                        state_d = C2S_READY;           // arm
                end
                C2M_PULSE: state_d = data_rd ? C2S_PULSE : C2S_READY;   // read-drop / pulse-end
                default:   state_d = C2S_INPUT;
            endcase
        end
    end

    always_comb begin
        c2_oe  = 1'b1;
        c2_out = 1'b1;
        unique case (state_q)
            C2S_INPUT:                               c2_oe  = 1'b0;
            C2S_LEVEL_LOW, C2S_HS_WAIT, C2S_PULSE:   c2_out = 1'b0;
            C2S_LEVEL_HIGH, C2S_READY:               c2_out = 1'b1;
            default:                                 c2_oe  = 1'b0;
        endcase
    end
endmodule

// File: rtl/pia_port_unit.sv
module pia_port_unit
    import pia_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_sel,
    input  logic              wr_ctl,
    input  logic              rd_data_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              c1_pin,
    input  logic              c2_pin,
    output logic [CTL_W-1:0]  ctl_q,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] ddr_q,
    output logic [DATA_W-1:0] view,
    output logic              c2_out,
    output logic              c2_oe,
    output logic              irq_part,
    output logic              c1_hit,
    output logic              c2_hit
);
    logic c1_rise, c1_fall, c2_rise, c2_fall;
    logic data_rd;
    logic dir_next;

    pia_edge_sync #(.STAGES(SYNC_STAGES)) u_c1_sync (
        .clk(clk), .rst_n(rst_n), .pin(c1_pin), .rise(c1_rise), .fall(c1_fall)
    );
    pia_edge_sync #(.STAGES(SYNC_STAGES)) u_c2_sync (
        .clk(clk), .rst_n(rst_n), .pin(c2_pin), .rise(c2_rise), .fall(c2_fall)
    );

    assign data_rd  = rd_data_sel & ctl_q[B_SEL];
    assign c1_hit   = ctl_q[B_C1_POL] ? c1_rise : c1_fall;
    assign c2_hit   = ~ctl_q[B_C2_DIR] & (ctl_q[B_C2_CFG_HI] ? c2_rise : c2_fall);
    assign dir_next = wr_ctl ? wdata[B_C2_DIR] : ctl_q[B_C2_DIR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            out_q <= '0;
            ddr_q <= '0;
        end else begin
            if (wr_data_sel) begin
                if (ctl_q[B_SEL]) out_q <= wdata;
                else              ddr_q <= wdata;
            end
            if (wr_ctl) ctl_q[B_C2_DIR:0] <= wdata[B_C2_DIR:0];
            ctl_q[B_C1_FLAG] <= c1_hit | (ctl_q[B_C1_FLAG] & ~data_rd);
            ctl_q[B_C2_FLAG] <= ~dir_next & (c2_hit | (ctl_q[B_C2_FLAG] & ~data_rd));
        end
    end

    assign view = ctl_q[B_SEL] ? ((pin_in & ~ddr_q) | (out_q & ddr_q)) : ddr_q;

    assign irq_part = (ctl_q[B_C1_FLAG] & ctl_q[B_C1_EN])
                    | (ctl_q[B_C2_FLAG] & ~ctl_q[B_C2_DIR] & ctl_q[B_C2_CFG_LO]);

    pia_c2_fsm u_c2_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (ctl_q[B_C2_DIR:B_C2_CFG_LO]),
        .data_rd   (data_rd),
        .c1_active (c1_hit),
        .c2_out    (c2_out),
        .c2_oe     (c2_oe)
    );
endmodule

// File: rtl/byte_port_adapter.sv
module byte_port_adapter
    import pia_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              dbg_rd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_dir,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_dir,
    input  logic              ca1_in,
    input  logic              ca2_in,
    output logic              ca2_out,
    output logic              ca2_oe,
    input  logic              cb1_in,
    input  logic              cb2_in,
    output logic              cb2_out,
    output logic              cb2_oe,
    output logic              irq
);
    localparam int NPORT = 2;

    logic [NPORT-1:0][DATA_W-1:0] pin_vec, out_vec, ddr_vec, view_vec;
    logic [NPORT-1:0][CTL_W-1:0]  ctl_vec;
    logic [NPORT-1:0] c1_vec, c2_vec, c2o_vec, c2oe_vec, irq_vec, c1_hit_vec, c2_hit_vec;
    logic sel_ctl, sel_port;
    logic unused_addr_hi;

    assign sel_ctl        = reg_addr[0];
    assign sel_port       = reg_addr[1];
    assign unused_addr_hi = ^reg_addr[ADDR_W-1:2];

    assign pin_vec[0] = pa_in;
    assign pin_vec[1] = pb_in;
    assign c1_vec     = {cb1_in, ca1_in};
    assign c2_vec     = {cb2_in, ca2_in};

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            logic hit;
            assign hit = (sel_port == 1'(p));
            pia_port_unit #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_port (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_data_sel (wr_en & hit & ~sel_ctl),
                .wr_ctl      (wr_en & hit & sel_ctl),
                .rd_data_sel (rd_en & hit & ~sel_ctl),
                .wdata       (wr_data),
                .pin_in      (pin_vec[p]),
                .c1_pin      (c1_vec[p]),
                .c2_pin      (c2_vec[p]),
                .ctl_q       (ctl_vec[p]),
                .out_q       (out_vec[p]),
                .ddr_q       (ddr_vec[p]),
                .view        (view_vec[p]),
                .c2_out      (c2o_vec[p]),
                .c2_oe       (c2oe_vec[p]),
                .irq_part    (irq_vec[p]),
                .c1_hit      (c1_hit_vec[p]),
                .c2_hit      (c2_hit_vec[p])
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_en | dbg_rd) begin
            if (sel_ctl) rd_data[CTL_W-1:0] = ctl_vec[sel_port];
            else         rd_data = view_vec[sel_port];
        end
    end

    assign pa_out  = out_vec[0];
    assign pa_dir  = ddr_vec[0];
    assign pb_out  = out_vec[1];
    assign pb_dir  = ddr_vec[1];
    assign ca2_out = c2o_vec[0];
    assign ca2_oe  = c2oe_vec[0];
    assign cb2_out = c2o_vec[1];
    assign cb2_oe  = c2oe_vec[1];
    assign irq     = |irq_vec;
endmodule

// File: rtl/pia_adapter_checker.sv
module pia_adapter_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic              dbg_rd,
    input logic [7:0]        ctl_a,
    input logic [7:0]        ctl_b,
    input logic              hit_a,
    input logic              c1_hit_a,
    input logic              ca2_out,
    input logic              ca2_oe,
    input logic              irq
);
    AST_C2_OUTPUT_NO_FLAG_A: assert property (@(posedge clk) disable iff (!rst_n) ctl_a[5] |-> !ctl_a[6]); // R5
    AST_C2_OUTPUT_NO_FLAG_B: assert property (@(posedge clk) disable iff (!rst_n) ctl_b[5] |-> !ctl_b[6]); // R5
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl_a[7] | ctl_a[6] | ctl_b[7] | ctl_b[6])); // R6
    AST_FLAG_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr[1:0] == 2'b01 && !c1_hit_a) |=> (ctl_a[7] == $past(ctl_a[7]))); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr[1:0] == 2'b00 && ctl_a[2] && !hit_a) |=> (ctl_a[7:6] == 2'b00)); // R7
    AST_DEBUG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rd && !rd_en && ctl_a[7]) |=> ctl_a[7]); // R8
    AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_a[5:3] == 3'b111 && !wr_en) |=> (ca2_oe && ca2_out)); // R9
    AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_a[5:3] == 3'b110 && !wr_en) |=> (ca2_oe && !ca2_out)); // R9
    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_a[5:3] == 3'b101 && !ca2_out && !wr_en && !rd_en) |=> ca2_out); // R11
    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_a[5] && !wr_en) |=> !ca2_oe); // R5
endmodule

bind byte_port_adapter pia_adapter_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .dbg_rd   (dbg_rd),
    .ctl_a    (ctl_vec[0]),
    .ctl_b    (ctl_vec[1]),
    .hit_a    (c1_hit_vec[0] | c2_hit_vec[0]),
    .c1_hit_a (c1_hit_vec[0]),
    .ca2_out  (ca2_out),
    .ca2_oe   (ca2_oe),
    .irq      (irq)
);

// File: tb/byte_port_adapter_tb_top.sv
module byte_port_adapter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0, dbg_rd = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] pa_in = '0, pb_in = '0;
    logic [7:0] pa_out, pa_dir, pb_out, pb_dir;
    logic       ca1_in = 1'b0, ca2_in = 1'b0, cb1_in = 1'b0, cb2_in = 1'b0;
    logic       ca2_out, ca2_oe, cb2_out, cb2_oe, irq;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    byte_port_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
        .dbg_rd(dbg_rd), .wr_data(wr_data), .rd_data(rd_data),
        .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
        .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
        .ca1_in(ca1_in), .ca2_in(ca2_in), .ca2_out(ca2_out), .ca2_oe(ca2_oe),
        .cb1_in(cb1_in), .cb2_in(cb2_in), .cb2_out(cb2_out), .cb2_oe(cb2_oe),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        dbg_rd = 1'b1; reg_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        dbg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(4'd1, v); check("R12 ctl A", v, 8'h00);
        peek(4'd3, v); check("R12 ctl B", v, 8'h00);
        check("R12 dir A", pa_dir, 8'h00);
        check("R12 dir B", pb_dir, 8'h00);
        check("R12 out A", pa_out, 8'h00);
        check("R12 irq", {7'd0, irq}, 8'h00);
        check("R5 c2 released", {7'd0, ca2_oe}, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] v;
        wr(4'd0, 8'h0F);
        peek(4'd0, v);    check("R1 dir readback", v, 8'h0F);
        check("R1 dir pins", pa_dir, 8'h0F);
        wr(4'd1, 8'h04);
        wr(4'd0, 8'hA5);
        check("R1 out reg", pa_out, 8'hA5);
        check("R1 dir kept", pa_dir, 8'h0F);
        pa_in = 8'h3C;
        peek(4'd0, v);    check("R2 mix", v, 8'h35);
        wr(4'hF, 8'h04);
        peek(4'd3, v);    check("R13 alias ctl B", v, 8'h04);
        pb_in = 8'h9A;
        peek(4'h6, v);    check("R13 alias data B", v, 8'h9A);
        wr(4'd1, 8'hC4);
        peek(4'd1, v);    check("R3 flags read-only", v, 8'h04);
    endtask

    task automatic t_c1();
        logic [7:0] v;
        ca1_in = 1'b1; settle();
        peek(4'd1, v);    check("R4 wrong edge ignored", v, 8'h04);
        ca1_in = 1'b0; settle();
        peek(4'd1, v);    check("R4 falling sets", v, 8'h84);
        check("R6 masked", {7'd0, irq}, 8'h00);
        wr(4'd1, 8'h05);
        check("R6 c1 irq", {7'd0, irq}, 8'h01);
        rd(4'd0, v);
        peek(4'd1, v);    check("R7 data read clears", v, 8'h05);
        check("R7 irq drop", {7'd0, irq}, 8'h00);
        settle();
        peek(4'd1, v);    check("R4 sets once", v, 8'h05);
        wr(4'd1, 8'h07);
        ca1_in = 1'b1; settle();
        peek(4'd1, v);    check("R4 rising sets", v, 8'h87);
        peek(4'd0, v);
        peek(4'd1, v);    check("R8 debug read keeps", v, 8'h87);
        wr(4'd1, 8'h03);
        rd(4'd0, v);      check("R1 dir read", v, 8'h0F);
        peek(4'd1, v);    check("R7 dir read keeps", v, 8'h83);
        wr(4'd1, 8'h07);
        rd(4'd0, v);
        peek(4'd1, v);    check("R7 cleared", v, 8'h07);
    endtask

    task automatic t_c2_in();
        logic [7:0] v;
        wr(4'd1, 8'h0C);
        ca2_in = 1'b1; settle();
        peek(4'd1, v);    check("R5 wrong edge ignored", v, 8'h0C);
        ca2_in = 1'b0; settle();
        peek(4'd1, v);    check("R5 c2 flag", v, 8'h4C);
        check("R6 c2 irq", {7'd0, irq}, 8'h01);
        wr(4'd1, 8'h2C);
        peek(4'd1, v);    check("R5 output clears flag", v, 8'h2C);
        check("R6 irq gone", {7'd0, irq}, 8'h00);
        ca2_in = 1'b1; settle();
        ca2_in = 1'b0; settle();
        peek(4'd1, v);    check("R5 output ignores pin", v, 8'h2C);
    endtask

    task automatic t_pulse();
        logic [7:0] v;
        check("R11 idle high", {6'd0, ca2_oe, ca2_out}, 8'h03);
        rd(4'd0, v);
        check("R11 low after read", {7'd0, ca2_out}, 8'h00);
        @(negedge clk);
        check("R11 one clock only", {7'd0, ca2_out}, 8'h01);
    endtask

    task automatic t_handshake();
        logic [7:0] v;
        wr(4'd1, 8'h24);
        @(negedge clk);
        check("R10 ready high", {7'd0, ca2_out}, 8'h01);
        rd(4'd0, v);
        check("R10 low after read", {7'd0, ca2_out}, 8'h00);
        repeat (3) @(negedge clk);
        check("R10 held low", {7'd0, ca2_out}, 8'h00);
        ca1_in = 1'b0; settle();
        check("R10 released by C1", {7'd0, ca2_out}, 8'h01);
        peek(4'd1, v);    check("R4 flag in handshake", v, 8'hA4);
    endtask

    task automatic t_manual();
        wr(4'd1, 8'h34);
        @(negedge clk);
        check("R9 low", {6'd0, ca2_oe, ca2_out}, 8'h02);
        wr(4'd1, 8'h3C);
        @(negedge clk);
        check("R9 high", {6'd0, ca2_oe, ca2_out}, 8'h03);
    endtask

    task automatic t_port_b();
        logic [7:0] v;
        wr(4'd3, 8'h00);
        wr(4'd2, 8'hFF);
        peek(4'd2, v);    check("R1 B dir", v, 8'hFF);
        wr(4'd3, 8'h04);
        wr(4'd2, 8'h5A);
        check("R1 B out", pb_out, 8'h5A);
        peek(4'd2, v);    check("R2 B all output", v, 8'h5A);
        check("R5 B released", {7'd0, cb2_oe}, 8'h00);
        wr(4'd3, 8'h07);
        cb1_in = 1'b1; settle();
        peek(4'd3, v);    check("R4 B rising", v, 8'h87);
        check("R6 B irq", {7'd0, irq}, 8'h01);
        rd(4'd2, v);
        check("R7 B clear irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_c1();
        t_c2_in();
        t_pulse();
        t_handshake();
        t_manual();
        t_port_b();
        t_reset_again();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule